// File: doc/BRIEF.md
# Paged Network Controller Register File

This block is the byte-wide control and status register file of a small Ethernet controller. A host reaches it through a narrow address bus. Only the low five bits of that address select a register. A shared command register chooses which of three register pages the other offsets reach. The command register is reachable at offset 0 on every page. Reads and writes at one offset on one page need not reach the same register. For example, a read at page 0 offset 4 returns the transmit status, while a write at that offset loads the transmit page.

The receive and DMA logic around the block report events as set pulses into the interrupt status register. A writable interrupt mask gates those bits onto a level interrupt output. Writes to the command register also have side effects:
- leaving the stopped state clears the reset-status flag;
- a remote-DMA command given while the remote byte count is zero completes at once;
- a transmit command is acknowledged only as status (transmit status, interrupt bit and self-clearing command bit). No frame is sent.

The read data path is combinational and qualified by the read strobe. Writes take effect at the clock edge that samples the write strobe.

Top module: `nic_paged_csr`

## Requirements
- R1: Only the low 5 bits of the host address select a register. Offset 0 reads and writes the command register whatever page is selected.
- R2: Command bits 7:6 select the page (0, 1 or 2) for offsets 1 to 15. Page 0 writes: 1 ring start, 2 ring stop, 3 boundary, 4 transmit page, 5/6 transmit count low/high, 7 interrupt status, 8/9 remote address low/high, 10/11 remote count low/high, 12 receive config, 13 transmit config, 14 data config, 15 interrupt mask. Page 0 reads: 3 boundary, 4 transmit status, 7 interrupt status. Page 1 reads and writes: 1 to 6 station address, 7 current page, 8 to 15 multicast mask. Page 2 reads: 1 ring start, 2 ring stop, 4 transmit page, 12 to 15 receive/transmit/data config and interrupt mask.
- R3: The interrupt output is high exactly when (status AND mask AND 0x7F) is nonzero. It reflects the registers of the current cycle.
- R4: A write to the interrupt status register clears every one of bits 6:0 that is written as 1 and leaves the other bits unchanged. Status bits are never cleared otherwise, except bit 7 as in R6.
- R5: After reset the command register reads 0x22, the interrupt status 0x80 (bit 7 = reset flag), the mask 0x00, the transmit status 0x00, and all multicast mask bytes 0xFF.
- R6: A command write with bit 0 (stop) clear clears status bit 7. A command write with bit 0 set leaves status bit 7 unchanged.
- R7: A command write with bit 0 clear and bit 2 (transmit) set does three things: it stores the command with bit 2 cleared, loads transmit status with 0x01, and sets status bit 1. With bit 0 set, none of these happen and the command is stored as written.
- R8: A command write with bit 0 clear and either bit 3 (remote read) or bit 4 (remote write) set sets status bit 6 when the 16-bit remote byte count is zero, and does not set it otherwise.
- R9: Each 16-bit register is written as a low byte and a high byte at separate offsets, and a write of one half keeps the other half.
- R10: Offsets with no register on the selected page read as 0x00, writes there change nothing, and offsets 16 to 31 and page 3 hold no registers.
- R11: A pulse on event input bit n (n = 0 to 6) sets status bit n. The set wins over a clear of the same bit written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one byte |
| rd_en | input | 1 | Read strobe that qualifies rdata |
| addr | input | HOST_AW | Host address; only bits 4:0 are decoded |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 0 when rd_en is low |
| evt_set | input | 7 | Set pulses for interrupt status bits 6:0 |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions take for granted that the host asserts at most one of the read and write strobes in a cycle. They also assume the write strobe is held for exactly one clock per access. Event pulses may arrive in any cycle, including the same cycle as a status-clear write; the collision case is driven on purpose to check that the set wins. The directed tasks drive one access per clock from the falling edge and sample read data a moment later. This keeps every strobe single-cycle and lets each status change be observed through the ordinary read path before the next access.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

   localparam int OFS_W = 5;

   // offsets shared by page 0 (and partly page 2)
   localparam logic [OFS_W-1:0] OFS_CMD   = 5'h00;
   localparam logic [OFS_W-1:0] OFS_START = 5'h01;
   localparam logic [OFS_W-1:0] OFS_STOP  = 5'h02;
   localparam logic [OFS_W-1:0] OFS_BNDY  = 5'h03;
   localparam logic [OFS_W-1:0] OFS_TXPG  = 5'h04;
   localparam logic [OFS_W-1:0] OFS_ISR   = 5'h07;
   localparam logic [OFS_W-1:0] OFS_RXCFG = 5'h0C;
   localparam logic [OFS_W-1:0] OFS_TXCFG = 5'h0D;
   localparam logic [OFS_W-1:0] OFS_DCFG  = 5'h0E;
   localparam logic [OFS_W-1:0] OFS_IMR   = 5'h0F;

   // command bit positions
   localparam int CB_STOP = 0;
   localparam int CB_XMIT = 2;
   localparam int CB_RRD  = 3;
   localparam int CB_RWR  = 4;

   // interrupt status bit positions
   localparam int IB_RX   = 0;
   localparam int IB_TX   = 1;
   localparam int IB_RDMA = 6;
   localparam int IB_RST  = 7;

   localparam logic [7:0] CMD_RST_VAL = 8'h22;
   localparam logic [7:0] ISR_RST_VAL = 8'h80;
   localparam logic [7:0] TXST_OK     = 8'h01;

   typedef enum logic [1:0] {PG_0 = 2'd0, PG_1 = 2'd1, PG_2 = 2'd2, PG_3 = 2'd3} page_e;

   // split 16-bit registers: 0 transmit count, 1 remote address, 2 remote count
   localparam int N_WIDE = 3;

   function automatic logic [OFS_W-1:0] wide_lo_ofs(input int idx);
      case (idx)
         0:       return 5'h05;
         1:       return 5'h08;
         default: return 5'h0A;
      endcase
   endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
   import nic_csr_pkg::*;
#(
   parameter int HOST_AW = 16
) (
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [1:0]         page_bits,
   output logic [OFS_W-1:0]   ofs,
   output page_e              page,
   output logic               cmd_hit
);

   generate
      if (HOST_AW < OFS_W) begin : g_bad_aw
         $error("HOST_AW must cover the register offset");
      end
      if (HOST_AW > OFS_W) begin : g_hi
         logic unused_hi_bits;
         assign unused_hi_bits = ^host_addr[HOST_AW-1:OFS_W];
      end
   endgenerate

   assign ofs     = host_addr[OFS_W-1:0];
   assign page    = page_e'(page_bits);
   assign cmd_hit = (ofs == OFS_CMD);

endmodule

// File: rtl/csr_wide_reg.sv
module csr_wide_reg #(
   parameter int          W       = 16,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_lo,
   input  logic         we_hi,
   input  logic [7:0]   wdata,
   output logic [W-1:0] q
);

   localparam int HI_W = W - 8;

   generate
      if (W <= 8 || W > 16) begin : g_bad_w
         $error("csr_wide_reg width must be 9..16");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_VAL;
      end else begin
         if (we_lo) q[7:0]   <= wdata;
         if (we_hi) q[W-1:8] <= wdata[HI_W-1:0];
      end
   end

   // R9
   half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_lo && !we_hi) |=> $stable(q[W-1:8]));

endmodule

// File: rtl/csr_irq_ctrl.sv
module csr_irq_ctrl
   import nic_csr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_we,
   input  logic       imr_we,
   input  logic [7:0] wdata,
   input  logic       rst_flag_clr,
   input  logic [6:0] set_vec,
   output logic [7:0] isr,
   output logic [7:0] imr,
   output logic       irq
);

   logic [7:0] isr_nxt;

   always_comb begin
      isr_nxt = isr;
      if (clr_we)       isr_nxt[6:0]   = isr_nxt[6:0] & ~wdata[6:0];
      if (rst_flag_clr) isr_nxt[IB_RST] = 1'b0;
      isr_nxt[6:0] = isr_nxt[6:0] | set_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr <= ISR_RST_VAL;
         imr <= 8'h00;
      end else begin
         isr <= isr_nxt;
         if (imr_we) imr <= wdata;
      end
   end

   assign irq = |(isr[6:0] & imr[6:0]);

   // R4
   isr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && ((set_vec & wdata[6:0]) == 7'd0)) |=> ((isr[6:0] & $past(wdata[6:0])) == 7'd0));

   // R4
   isr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_we && !rst_flag_clr) |=> ((isr & $past(isr)) == $past(isr)));

   // R11
   evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((isr[6:0] & $past(set_vec)) == $past(set_vec)));

   // R3
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(imr_we || (|set_vec)));

endmodule

// File: rtl/nic_paged_csr.sv
module nic_paged_csr
   import nic_csr_pkg::*;
#(
   parameter int HOST_AW   = 16,
   parameter int STA_BYTES = 6,
   parameter int MC_BYTES  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [HOST_AW-1:0] addr,
   input  logic [7:0]         wdata,
   output logic [7:0]         rdata,
   input  logic [6:0]         evt_set,
   output logic               irq
);

   localparam logic [OFS_W-1:0] CURPG_OFS = OFS_W'(STA_BYTES + 1);
   localparam int               MC_BASE   = STA_BYTES + 2;

   generate
      if (STA_BYTES + MC_BYTES + 1 != 15) begin : g_bad_map
         $error("page 1 must fill offsets 1..15 exactly");
      end
      if (MC_BYTES < 1 || STA_BYTES < 1) begin : g_bad_cnt
         $error("station and multicast byte counts must be positive");
      end
   endgenerate

   logic [7:0]       cmd_q, start_q, stop_q, bnd_q, txpg_q, txst_q;
   logic [7:0]       rxcfg_q, txcfg_q, dcfg_q, curpg_q;
   logic [7:0]       sta_q [STA_BYTES];
   logic [7:0]       mc_q  [MC_BYTES];
   logic [15:0]      wide_q [N_WIDE];
   logic [7:0]       isr, imr;
   logic [OFS_W-1:0] ofs;
   page_e            page;
   logic             cmd_hit;

   csr_addr_decode #(.HOST_AW(HOST_AW)) u_dec (
      .host_addr (addr),
      .page_bits (cmd_q[7:6]),
      .ofs       (ofs),
      .page      (page),
      .cmd_hit   (cmd_hit)
   );

   logic cmd_we, go, do_xmit, rdma_req, rdma_zero;
   logic wr_p0, wr_p1;

   assign cmd_we    = wr_en && cmd_hit;
   assign go        = cmd_we && !wdata[CB_STOP];
   assign do_xmit   = go && wdata[CB_XMIT];
   assign rdma_req  = go && (wdata[CB_RRD] || wdata[CB_RWR]);
   assign rdma_zero = (wide_q[2] == 16'd0);
   assign wr_p0     = wr_en && !cmd_hit && (page == PG_0);
   assign wr_p1     = wr_en && !cmd_hit && (page == PG_1);

   // command register and page-0 byte registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= CMD_RST_VAL;
         start_q <= 8'h00;
         stop_q  <= 8'h00;
         bnd_q   <= 8'h00;
         txpg_q  <= 8'h00;
         txst_q  <= 8'h00;
         rxcfg_q <= 8'h00;
         txcfg_q <= 8'h00;
         dcfg_q  <= 8'h00;
      end else begin
         if (cmd_we) begin
            cmd_q <= wdata;
            if (do_xmit) cmd_q[CB_XMIT] <= 1'b0;
         end
         if (do_xmit) txst_q <= TXST_OK;
         if (wr_p0) begin
            case (ofs)
               OFS_START: start_q <= wdata;
               OFS_STOP:  stop_q  <= wdata;
               OFS_BNDY:  bnd_q   <= wdata;
               OFS_TXPG:  txpg_q  <= wdata;
               OFS_RXCFG: rxcfg_q <= wdata;
               OFS_TXCFG: txcfg_q <= wdata;
               OFS_DCFG:  dcfg_q  <= wdata;
               default: ;
            endcase
         end
      end
   end

   // split 16-bit registers on page 0
   generate
      for (genvar w = 0; w < N_WIDE; w++) begin : g_wide
         localparam logic [OFS_W-1:0] LO = wide_lo_ofs(w);
         csr_wide_reg #(.W(16), .RST_VAL(16'h0000)) u_wide (
            .clk   (clk),
            .rst_n (rst_n),
            .we_lo (wr_p0 && (ofs == LO)),
            .we_hi (wr_p0 && (ofs == LO + 5'd1)),
            .wdata (wdata),
            .q     (wide_q[w])
         );
      end
   endgenerate

   logic unused_wide;
   assign unused_wide = ^{wide_q[0], wide_q[1]};

   // page-1 station address, current page, multicast mask
   generate
      for (genvar s = 0; s < STA_BYTES; s++) begin : g_sta
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                sta_q[s] <= 8'h00;
            else if (wr_p1 && ofs == OFS_W'(1 + s))    sta_q[s] <= wdata;
         end
      end
      for (genvar m = 0; m < MC_BYTES; m++) begin : g_mc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  mc_q[m] <= 8'hFF;
            else if (wr_p1 && ofs == OFS_W'(MC_BASE + m)) mc_q[m] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          curpg_q <= 8'h00;
      else if (wr_p1 && ofs == CURPG_OFS)  curpg_q <= wdata;
   end

   // interrupt status and mask
   logic [6:0] set_vec;
   always_comb begin
      set_vec          = evt_set;
      set_vec[IB_TX]   = evt_set[IB_TX]   | do_xmit;
      set_vec[IB_RDMA] = evt_set[IB_RDMA] | (rdma_req && rdma_zero);
   end

   csr_irq_ctrl u_irq (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_we       (wr_p0 && ofs == OFS_ISR),
      .imr_we       (wr_p0 && ofs == OFS_IMR),
      .wdata        (wdata),
      .rst_flag_clr (go),
      .set_vec      (set_vec),
      .isr          (isr),
      .imr          (imr),
      .irq          (irq)
   );

   // read mux
   logic [7:0] rd_mux;
   always_comb begin
      rd_mux = 8'h00;
      if (cmd_hit) begin
         rd_mux = cmd_q;
      end else begin
         case (page)
            PG_0: begin
               case (ofs)
                  OFS_BNDY: rd_mux = bnd_q;
                  OFS_TXPG: rd_mux = txst_q;
                  OFS_ISR:  rd_mux = isr;
                  default:  rd_mux = 8'h00;
               endcase
            end
            PG_1: begin
               for (int s = 0; s < STA_BYTES; s++)
                  if (ofs == OFS_W'(1 + s)) rd_mux = sta_q[s];
               if (ofs == CURPG_OFS) rd_mux = curpg_q;
               for (int m = 0; m < MC_BYTES; m++)
                  if (ofs == OFS_W'(MC_BASE + m)) rd_mux = mc_q[m];
            end
            PG_2: begin
               case (ofs)
                  OFS_START: rd_mux = start_q;
                  OFS_STOP:  rd_mux = stop_q;
                  OFS_TXPG:  rd_mux = txpg_q;
                  OFS_RXCFG: rd_mux = rxcfg_q;
                  OFS_TXCFG: rd_mux = txcfg_q;
                  OFS_DCFG:  rd_mux = dcfg_q;
                  OFS_IMR:   rd_mux = imr;
                  default:   rd_mux = 8'h00;
               endcase
            end
            default: rd_mux = 8'h00;
         endcase
      end
   end

   assign rdata = rd_en ? rd_mux : 8'h00;

   // R7
   xmit_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !wdata[CB_STOP] && wdata[CB_XMIT]) |=>
         (!cmd_q[CB_XMIT] && txst_q == TXST_OK && isr[IB_TX]));

   // R6
   rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !wdata[CB_STOP]) |=> !isr[IB_RST]);

   // R8
   rdma_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !wdata[CB_STOP] && (wdata[CB_RRD] || wdata[CB_RWR]) && wide_q[2] == 16'd0)
         |=> isr[IB_RDMA]);

   // R10
   hi_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[4]) |=> ($stable(cmd_q) && $stable(bnd_q) && $stable(imr) && $stable(curpg_q)));

endmodule

// File: tb/sim_nic_paged_csr.sv
`timescale 1ns/1ps
module sim_nic_paged_csr;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [6:0]  evt_set = '0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nic_paged_csr u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .evt_set(evt_set), .irq(irq)
   );

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      rd_en = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   task automatic pulse_evt(input logic [6:0] v);
      @(negedge clk);
      evt_set = v;
      @(negedge clk);
      evt_set = '0;
   endtask

   task automatic t_reset;
      rd_chk("R5 cmd reset", 16'h0000, 8'h22);
      rd_chk("R5 isr reset", 16'h0007, 8'h80);
      check("R3 irq idle", {7'd0, irq}, 8'h00);
      rd_chk("R5 txstat reset", 16'h0004, 8'h00);
      wr(16'h0000, 8'h61);
      for (int j = 0; j < 8; j++) rd_chk("R5 mcast reset", 16'(8 + j), 8'hFF);
      wr(16'h0000, 8'hA1);
      rd_chk("R5 imr reset", 16'h000F, 8'h00);
      rd_chk("R1 cmd on page 2", 16'h0000, 8'hA1);
      wr(16'h0000, 8'h21);
      rd_chk("R6 stop keeps flag", 16'h0007, 8'h80);
      wr(16'h0000, 8'h22);
      rd_chk("R6 flag cleared", 16'h0007, 8'h00);
   endtask

   task automatic t_paging;
      wr(16'hC1E3, 8'h4C);
      wr(16'h0001, 8'h46);
      wr(16'h0002, 8'h80);
      wr(16'h0004, 8'h40);
      wr(16'h0000, 8'h62);
      wr(16'h0003, 8'hAB);
      wr(16'h0007, 8'h4D);
      wr(16'h0009, 8'h12);
      rd_chk("R2 p1 station", 16'h0003, 8'hAB);
      rd_chk("R2 p1 curpage", 16'h0007, 8'h4D);
      rd_chk("R2 p1 mcast", 16'h0009, 8'h12);
      wr(16'h0000, 8'hA2);
      rd_chk("R2 p2 start", 16'h0001, 8'h46);
      rd_chk("R2 p2 stop", 16'h0002, 8'h80);
      rd_chk("R2 p2 txpage", 16'h0004, 8'h40);
      rd_chk("R10 p2 unmapped", 16'h0003, 8'h00);
      wr(16'h0000, 8'h22);
      rd_chk("R1 masked boundary", 16'h0003, 8'h4C);
      rd_chk("R10 p0 unmapped", 16'h0001, 8'h00);
      wr(16'h0000, 8'hE2);
      wr(16'h0003, 8'h99);
      rd_chk("R10 page3 read", 16'h0003, 8'h00);
      wr(16'h0000, 8'h22);
      rd_chk("R10 page3 write ignored", 16'h0003, 8'h4C);
      wr(16'h0013, 8'h77);
      rd_chk("R10 hi ofs write ignored", 16'h0003, 8'h4C);
      rd_chk("R10 hi ofs read", 16'h0013, 8'h00);
   endtask

   task automatic t_irq;
      wr(16'h000F, 8'h01);
      check("R3 no status", {7'd0, irq}, 8'h00);
      pulse_evt(7'h01);
      check("R3 irq raised", {7'd0, irq}, 8'h01);
      rd_chk("R11 event sets bit", 16'h0007, 8'h01);
      pulse_evt(7'h20);
      rd_chk("R11 second event", 16'h0007, 8'h21);
      wr(16'h0007, 8'h01);
      rd_chk("R4 clear one bit", 16'h0007, 8'h20);
      check("R3 masked bit", {7'd0, irq}, 8'h00);
      wr(16'h0007, 8'h20);
      rd_chk("R4 clear all", 16'h0007, 8'h00);
   endtask

   task automatic t_collide;
      @(negedge clk);
      evt_set = 7'h01; addr = 16'h0007; wdata = 8'h01; wr_en = 1'b1;
      @(negedge clk);
      evt_set = '0; wr_en = 1'b0;
      rd_chk("R11 set beats clear", 16'h0007, 8'h01);
      check("R3 irq after collide", {7'd0, irq}, 8'h01);
      wr(16'h0007, 8'h01);
      check("R3 irq dropped", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_dma;
      wr(16'h000A, 8'h00);
      wr(16'h000B, 8'h01);
      wr(16'h0000, 8'h0A);
      rd_chk("R8 nonzero count", 16'h0007, 8'h00);
      rd_chk("R1 cmd stored", 16'h0000, 8'h0A);
      wr(16'h000A, 8'h00);
      wr(16'h0000, 8'h0A);
      rd_chk("R9 low write keeps high", 16'h0007, 8'h00);
      wr(16'h000B, 8'h00);
      wr(16'h0000, 8'h0B);
      rd_chk("R8 stopped no effect", 16'h0007, 8'h00);
      wr(16'h0000, 8'h12);
      rd_chk("R8 zero count completes", 16'h0007, 8'h40);
      wr(16'h0007, 8'h40);
      wr(16'h0000, 8'h22);
   endtask

   task automatic t_xmit;
      wr(16'h0000, 8'h26);
      rd_chk("R7 xmit bit self clears", 16'h0000, 8'h22);
      rd_chk("R7 txstat ok", 16'h0004, 8'h01);
      rd_chk("R7 tx status bit", 16'h0007, 8'h02);
      wr(16'h0007, 8'h02);
      wr(16'h0000, 8'h27);
      rd_chk("R7 stopped no tx", 16'h0007, 8'h00);
      rd_chk("R7 stopped cmd as written", 16'h0000, 8'h27);
      wr(16'h0000, 8'h22);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_paging();
      t_irq();
      t_collide();
      t_dma();
      t_xmit();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule